// File: doc/BRIEF.md
# Single-Coin Tea and Coffee Vending Controller

This block sequences a drink machine that takes one coin and then offers a three-way choice. After a coin pulse it waits for the customer to press tea, coffee or cancel. Cancel hands the coin back. Tea or coffee drives the matching dispense output. Dispensing ends when the mechanism reports it is finished, or when a parameterised number of cycles has passed, whichever comes first. The machine then goes back to waiting for the next coin.

All inputs are single-cycle or level control signals sampled on the rising clock edge. All outputs are plain control pins. No data stream passes through the block, so it has no valid/ready handshake. Reset is synchronous and active low.

Top module: `vend_ctrl`

## Requirements
- R1: After reset the machine idles waiting for a coin, and coin_return, tea_on and coffee_on are all 0.
- R2: A coin pulse while idle moves the machine to the selection phase. Buttons pressed while idle do nothing.
- R3: In the selection phase, cancel produces a coin_return pulse exactly one cycle long, in the cycle after the press, and the machine goes back to idle.
- R4: In the selection phase, tea (with cancel low) starts tea dispensing. tea_on goes high in the cycle after the press.
- R5: In the selection phase, coffee (with cancel and tea low) starts coffee dispensing. coffee_on goes high in the cycle after the press.
- R6: Priority when buttons are pressed together: cancel beats tea, and tea beats coffee.
- R7: A dispense output stays high for the whole dispense phase. tea_on and coffee_on are never high together.
- R8: A dispense phase with done never asserted lasts exactly DISP_CYCLES cycles, then the machine returns to idle.
- R9: Asserting done ends the dispense phase. The output is low in the next cycle.
- R10: Coin pulses outside the idle state are ignored: a coin during selection or dispensing has no effect. Buttons during dispensing are ignored.
- R11: The machine waits in the selection phase for as long as no button is pressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| coin_in | input | 1 | Coin accepted pulse |
| btn_tea | input | 1 | Tea selection button |
| btn_coffee | input | 1 | Coffee selection button |
| btn_cancel | input | 1 | Cancel button |
| disp_done | input | 1 | Dispense mechanism finished |
| coin_return | output | 1 | One-cycle coin eject pulse |
| tea_on | output | 1 | Tea dispense level |
| coffee_on | output | 1 | Coffee dispense level |

## Verification
The bench presses buttons together to check the priority order. A design with the wrong order would pour a drink when cancel was pressed, or pour coffee when tea was pressed with it.

It measures the length of a dispense phase when done is never asserted. An off-by-one timer would hold the output for DISP_CYCLES plus or minus one cycles.

It sends coins during selection and during dispensing, and buttons while idle. A design that does not gate these would leave the dispense phase early, or start pouring without a coin.

It also checks that coin_return lasts exactly one cycle. A design that holds it as a level would eject coins repeatedly.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SELECT = 2'd1,
    ST_TEA    = 2'd2,
    ST_COFFEE = 2'd3
  } vend_state_e;

  typedef enum logic [1:0] {
    PICK_NONE   = 2'd0,
    PICK_CANCEL = 2'd1,
    PICK_TEA    = 2'd2,
    PICK_COFFEE = 2'd3
  } vend_pick_e;
endpackage

// File: rtl/vend_pick.sv
module vend_pick
  import vend_pkg::*;
(
  input  logic       tea,
  input  logic       coffee,
  input  logic       cancel,
  output vend_pick_e pick
);
  // Fixed priority: cancel, then tea, then coffee.
  always_comb begin
    if (cancel)      pick = PICK_CANCEL;
    else if (tea)    pick = PICK_TEA;
    else if (coffee) pick = PICK_COFFEE;
    else             pick = PICK_NONE;
  end
endmodule

// File: rtl/vend_timer.sv
module vend_timer #(
  parameter int CYCLES = 16,
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt;

  // Counts cycles spent in a dispense state. expire is high in the last one.
  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expire)   cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CW'(CYCLES - 1));
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int DISP_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic coin_in,
  input  logic btn_tea,
  input  logic btn_coffee,
  input  logic btn_cancel,
  input  logic disp_done,
  output logic coin_return,
  output logic tea_on,
  output logic coffee_on
);
  vend_state_e state, state_nx;
  vend_pick_e  pick;
  logic        dispensing, expire, finish, eject_nx;

  vend_pick u_pick (
    .tea   (btn_tea),
    .coffee(btn_coffee),
    .cancel(btn_cancel),
    .pick  (pick)
  );

  assign dispensing = (state == ST_TEA) || (state == ST_COFFEE);

  vend_timer #(.CYCLES(DISP_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (dispensing),
    .expire(expire)
  );

  assign finish = disp_done || expire;

  always_comb begin
    state_nx = state;
    eject_nx = 1'b0;
    unique case (state)
      ST_IDLE:   if (coin_in) state_nx = ST_SELECT;
      ST_SELECT: begin
        unique case (pick)
          PICK_CANCEL: begin
            state_nx = ST_IDLE;
            eject_nx = 1'b1;
          end
          PICK_TEA:    state_nx = ST_TEA;
          PICK_COFFEE: state_nx = ST_COFFEE;
          default:     state_nx = ST_SELECT;
        endcase
      end
      ST_TEA, ST_COFFEE: if (finish) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      coin_return <= 1'b0;
    end else begin
      state       <= state_nx;
      coin_return <= eject_nx;
    end
  end

  assign tea_on    = (state == ST_TEA);
  assign coffee_on = (state == ST_COFFEE);
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic coin_in,
  input logic btn_tea,
  input logic btn_coffee,
  input logic btn_cancel,
  input logic disp_done,
  input logic coin_return,
  input logic tea_on,
  input logic coffee_on
);
  // R7: the two drinks are never poured at once.
  a_r7_one_drink: assert property (@(posedge clk) disable iff (!rst_n)
    !(tea_on && coffee_on));

  // R3: coin_return is a single-cycle pulse.
  a_r3_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    coin_return |=> !coin_return);

  // R9: done ends tea dispensing.
  a_r9_done_tea: assert property (@(posedge clk) disable iff (!rst_n)
    (tea_on && disp_done) |=> !tea_on);

  // R9: done ends coffee dispensing.
  a_r9_done_coffee: assert property (@(posedge clk) disable iff (!rst_n)
    (coffee_on && disp_done) |=> !coffee_on);

  // R7: tea dispensing never turns into coffee dispensing directly.
  a_r7_tea_to_coffee: assert property (@(posedge clk) disable iff (!rst_n)
    tea_on |=> !coffee_on);

  // R3: no coin is ejected while a drink is being poured.
  a_r3_no_eject_disp: assert property (@(posedge clk) disable iff (!rst_n)
    (tea_on || coffee_on) |=> !coin_return);
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (.*);

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb;
  localparam int DISP = 6;

  logic clk = 0, rst_n = 0;
  logic coin_in = 0, btn_tea = 0, btn_coffee = 0, btn_cancel = 0, disp_done = 0;
  logic coin_return, tea_on, coffee_on;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  vend_ctrl #(.DISP_CYCLES(DISP)) u_dut (.*);

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {ret,tea,cof} act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {coin_return, tea_on, coffee_on};
  endfunction

  // Drive inputs for one cycle, then sample at the negative edge.
  task automatic step(input logic c, input logic t, input logic f,
                      input logic x, input logic d);
    coin_in = c; btn_tea = t; btn_coffee = f; btn_cancel = x; disp_done = d;
    @(negedge clk);
    coin_in = 0; btn_tea = 0; btn_coffee = 0; btn_cancel = 0; disp_done = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset", outs(), 3'b000);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_cancel();
    step(0, 1, 1, 0, 0);
    chk("R2 buttons while idle", outs(), 3'b000);
    step(1, 0, 0, 0, 0);
    repeat (3) step(0, 0, 0, 0, 0);
    chk("R11 selection waits", outs(), 3'b000);
    step(0, 0, 0, 1, 0);
    chk("R3 coin return", outs(), 3'b100);
    step(0, 0, 0, 0, 0);
    chk("R3 single pulse", outs(), 3'b000);
    step(0, 1, 0, 0, 0);
    chk("R3 back to idle", outs(), 3'b000);
  endtask

  task automatic t_tea_timeout();
    int n = 0;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R4 tea on", outs(), 3'b010);
    while (tea_on && n < 50) begin
      n++;
      step(1, 0, 1, 1, 0);
    end
    total++;
    if (n != DISP) begin
      bad++;
      $display("FAIL R8: length act=%0d exp=%0d", n, DISP);
    end
    chk("R10 coin during dispense ignored", outs(), 3'b000);
    step(0, 1, 0, 0, 0);
    chk("R10 no stored coin", outs(), 3'b000);
  endtask

  task automatic t_coffee_done();
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    chk("R5 coffee on", outs(), 3'b001);
    step(0, 0, 0, 0, 0);
    chk("R7 coffee held", outs(), 3'b001);
    step(0, 0, 0, 0, 1);
    chk("R9 done ends", outs(), 3'b000);
  endtask

  task automatic t_priority();
    step(1, 0, 0, 0, 0);
    step(0, 1, 1, 1, 0);
    chk("R6 cancel wins", outs(), 3'b100);
    step(1, 0, 0, 0, 0);
    step(0, 1, 1, 0, 0);
    chk("R6 tea over coffee", outs(), 3'b010);
    step(0, 0, 0, 0, 1);
    chk("R9 tea done", outs(), 3'b000);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_cancel();
    t_tea_timeout();
    t_coffee_done();
    t_priority();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule